// File: doc/BRIEF.md
# Set-Associative Address Translation Cache

This block holds recently used virtual-page to physical-frame translations for 4 KB pages. A requester presents a 32-bit virtual address with a write flag and a user flag. When a matching, permitted translation is resident, the block returns the physical address in the same cycle: the 20-bit frame number joined to the untranslated low 12 address bits. No memory table access takes place on that path. When there is no usable translation, the block raises a request to an external table walker. It then waits for the walker to install the translation through the fill port.

Each entry keeps a writable bit, a user bit and a dirty bit next to its frame number, so that access rights are checked on a hit. An access that breaks the rights of a resident entry ends in a protection fault, which carries the same three-bit error code the walker would produce. A write to a resident entry that is writable but not yet dirty is sent to the walker, so that the walker can mark the page dirty in memory. Any write of the directory base register drives `base_wr`, and that clears every entry.

The lookup port uses valid/ready. While `lk_valid` is high, `lk_ready` rises in the same cycle if the access completes, either as a hit or as a fault. If `lk_ready` stays low, the requester must hold its request stable until the fill arrives. `walk_valid` is a plain request level that mirrors the pending miss. The fill port has no back-pressure: a fill is accepted in every cycle in which `base_wr` is low.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid. A lookup then misses, and `lk_hit`, `lk_fault` and `lk_ready` stay low while `lk_valid` is low.
- R2: A lookup whose page is resident and whose access is permitted raises `lk_hit` and `lk_ready` in the same cycle. `lk_paddr` equals the stored frame number followed by `lk_vaddr[11:0]`.
- R3: A lookup without a usable entry raises `lk_miss` and `walk_valid`, keeps `lk_ready` low, and presents `walk_vpn = lk_vaddr[31:12]`.
- R4: The set is selected by the low log2(SETS) bits of the virtual page number, 4 bits by default. Each set holds WAYS entries, 4 by default. Fills into one set never disturb the entries of another set.
- R5: A fill into a set with a free way uses the lowest-numbered free way. When the set is full, a per-set round-robin pointer names the victim. The pointer starts at way 0 and advances by one on each eviction. In practice, the fifth distinct page filled into an empty set evicts the first page, and the sixth evicts the second.
- R6: A fill whose page is already resident in its set overwrites that entry in place. No other entry is evicted and the pointer does not move.
- R7: A write to a resident entry whose writable bit is 0 is a protection fault. `lk_fault` and `lk_ready` go high and there is no walk request. `lk_ecode` has bit 0 = 1 (the page is present), bit 1 = 1 for a write, and bit 2 = 1 for a user access. A supervisor read of the same entry hits.
- R8: A user access to a resident entry whose user bit is 0 is a protection fault, with `lk_ecode` bit 2 = 1. A user write to an entry that is both read-only and supervisor-only gives code 3'b111.
- R9: A write to a resident, writable entry whose dirty bit is 0 is treated as a miss (R3). Once the entry is filled again with the dirty bit set, the same write hits.
- R10: A cycle with `base_wr` high invalidates every entry. Lookups in the following cycles miss.
- R11: When `fill_valid` and `base_wr` are high in the same cycle, the flush wins and the fill is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup completed this cycle (hit or fault) |
| lk_vaddr | input | 32 | Virtual address of the lookup |
| lk_write | input | 1 | Access is a write |
| lk_user | input | 1 | Access is made at user privilege |
| lk_hit | output | 1 | Permitted translation found |
| lk_miss | output | 1 | No usable translation; walk needed |
| lk_fault | output | 1 | Protection fault on a resident entry |
| lk_ecode | output | 3 | Fault code: bit 0 present, bit 1 write, bit 2 user |
| lk_paddr | output | 32 | Physical address, valid with `lk_hit` |
| walk_valid | output | 1 | Request to the table walker |
| walk_vpn | output | 20 | Virtual page number to walk |
| fill_valid | input | 1 | Walker installs a translation |
| fill_vpn | input | 20 | Virtual page number of the fill |
| fill_pfn | input | 20 | Physical frame number of the fill |
| fill_writable | input | 1 | Page may be written |
| fill_user | input | 1 | Page is accessible at user privilege |
| fill_dirty | input | 1 | Page already marked dirty in memory |
| base_wr | input | 1 | Directory base register written; flush all |

## Verification
The properties assume that the requester holds `lk_vaddr`, `lk_write` and `lk_user` stable within a cycle, and that `base_wr` and `fill_valid` change only away from the clock edge. The bench drives every input one time unit after a rising edge and reads results on the falling edge, so these assumptions hold. The properties also assume that a flush cycle is not itself followed by a fill that restores a page being looked up in the next cycle. The bench keeps lookups and fills in separate cycles, and it always places one idle edge between a fill or flush and the next lookup.

// File: rtl/xc_pkg.sv
package xc_pkg;
  localparam int VPN_W   = 20;
  localparam int OFS_W   = 12;
  localparam int VA_W    = VPN_W + OFS_W;
  localparam int PFN_W   = 20;
  localparam int ECODE_W = 3;
  localparam int EC_PRES = 0;
  localparam int EC_WR   = 1;
  localparam int EC_USR  = 2;

  typedef struct packed {
    logic wr;
    logic usr;
    logic dirty;
  } perm_t;
endpackage

// File: rtl/xc_store.sv
module xc_store
  import xc_pkg::*;
#(
  parameter int SETS  = 16,
  parameter int WAYS  = 4,
  parameter int TAG_W = 16,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          flush,
  input  logic                          we,
  input  logic [IDX_W-1:0]              wr_set,
  input  logic [WAY_W-1:0]              wr_way,
  input  logic [TAG_W-1:0]              wr_tag,
  input  logic [PFN_W-1:0]              wr_pfn,
  input  perm_t                         wr_perm,
  input  logic [IDX_W-1:0]              a_set,
  output logic [WAYS-1:0]               a_valid,
  output logic [WAYS-1:0][TAG_W-1:0]    a_tag,
  output logic [WAYS-1:0][PFN_W-1:0]    a_pfn,
  output perm_t [WAYS-1:0]              a_perm,
  input  logic [IDX_W-1:0]              b_set,
  output logic [WAYS-1:0]               b_valid,
  output logic [WAYS-1:0][TAG_W-1:0]    b_tag
);
  logic [WAYS-1:0]            valid_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [WAYS-1:0][PFN_W-1:0] pfn_q   [SETS];
  perm_t [WAYS-1:0]           perm_q  [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
    end else if (we) begin
      valid_q[wr_set][wr_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we && !flush) begin
      tag_q[wr_set][wr_way]  <= wr_tag;
      pfn_q[wr_set][wr_way]  <= wr_pfn;
      perm_q[wr_set][wr_way] <= wr_perm;
    end
  end

  assign a_valid = valid_q[a_set];
  assign a_tag   = tag_q[a_set];
  assign a_pfn   = pfn_q[a_set];
  assign a_perm  = perm_q[a_set];
  assign b_valid = valid_q[b_set];
  assign b_tag   = tag_q[b_set];
endmodule

// File: rtl/xc_match.sv
module xc_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 16
) (
  input  logic [WAYS-1:0]            way_valid,
  input  logic [WAYS-1:0][TAG_W-1:0] way_tag,
  input  logic [TAG_W-1:0]           key,
  output logic [WAYS-1:0]            hit_vec,
  output logic                       hit_any
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = way_valid[w] && (way_tag[w] == key);
  end
  assign hit_any = |hit_vec;
endmodule

// File: rtl/xc_victim.sv
module xc_victim #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_set,
  input  logic [WAYS-1:0]  set_valid,
  input  logic [WAYS-1:0]  set_match,
  input  logic             match_any,
  output logic [WAY_W-1:0] way
);
  logic [WAY_W-1:0] rr_q [SETS];
  logic             free_any;
  logic [WAY_W-1:0] match_way;
  logic [WAY_W-1:0] free_way;

  always_comb begin
    match_way = '0;
    free_way  = '0;
    free_any  = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (set_match[w]) match_way = WAY_W'(w);
      if (!set_valid[w]) begin
        free_way = WAY_W'(w);
        free_any = 1'b1;
      end
    end
    if (match_any)     way = match_way;
    else if (free_any) way = free_way;
    else               way = rr_q[fill_set];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
    end else if (fill_en && !match_any && !free_any) begin
      if (rr_q[fill_set] == WAY_W'(WAYS - 1)) rr_q[fill_set] <= '0;
      else rr_q[fill_set] <= rr_q[fill_set] + 1'b1;
    end
  end
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xc_pkg::*;
#(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int TAG_W = VPN_W - IDX_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  output logic               lk_ready,
  input  logic [VA_W-1:0]    lk_vaddr,
  input  logic               lk_write,
  input  logic               lk_user,
  output logic               lk_hit,
  output logic               lk_miss,
  output logic               lk_fault,
  output logic [ECODE_W-1:0] lk_ecode,
  output logic [VA_W-1:0]    lk_paddr,
  output logic               walk_valid,
  output logic [VPN_W-1:0]   walk_vpn,
  input  logic               fill_valid,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [PFN_W-1:0]   fill_pfn,
  input  logic               fill_writable,
  input  logic               fill_user,
  input  logic               fill_dirty,
  input  logic               base_wr
);
  logic [VPN_W-1:0]           lk_vpn;
  logic [IDX_W-1:0]           lk_set, fl_set;
  logic [TAG_W-1:0]           lk_tag, fl_tag;
  logic [WAYS-1:0]            a_valid, b_valid;
  logic [WAYS-1:0][TAG_W-1:0] a_tag, b_tag;
  logic [WAYS-1:0][PFN_W-1:0] a_pfn;
  perm_t [WAYS-1:0]           a_perm;
  logic [WAYS-1:0]            a_hitv, b_hitv;
  logic                       a_hit, b_hit;
  logic [WAY_W-1:0]           fl_way;
  logic                       fill_en;
  perm_t                      fl_perm;
  logic [PFN_W-1:0]           sel_pfn;
  perm_t                      sel_perm;
  logic                       prot, clean_wr;

  assign lk_vpn  = lk_vaddr[VA_W-1:OFS_W];
  assign lk_set  = lk_vpn[IDX_W-1:0];
  assign lk_tag  = lk_vpn[VPN_W-1:IDX_W];
  assign fl_set  = fill_vpn[IDX_W-1:0];
  assign fl_tag  = fill_vpn[VPN_W-1:IDX_W];
  assign fill_en = fill_valid && !base_wr;
  assign fl_perm = '{wr: fill_writable, usr: fill_user, dirty: fill_dirty};

  xc_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(base_wr), .we(fill_en),
    .wr_set(fl_set), .wr_way(fl_way), .wr_tag(fl_tag), .wr_pfn(fill_pfn),
    .wr_perm(fl_perm),
    .a_set(lk_set), .a_valid(a_valid), .a_tag(a_tag), .a_pfn(a_pfn),
    .a_perm(a_perm),
    .b_set(fl_set), .b_valid(b_valid), .b_tag(b_tag)
  );

  xc_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_lk_match (
    .way_valid(a_valid), .way_tag(a_tag), .key(lk_tag),
    .hit_vec(a_hitv), .hit_any(a_hit)
  );

  xc_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_fl_match (
    .way_valid(b_valid), .way_tag(b_tag), .key(fl_tag),
    .hit_vec(b_hitv), .hit_any(b_hit)
  );

  xc_victim #(.SETS(SETS), .WAYS(WAYS)) u_victim (
    .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_set(fl_set),
    .set_valid(b_valid), .set_match(b_hitv), .match_any(b_hit),
    .way(fl_way)
  );

  always_comb begin
    sel_pfn  = '0;
    sel_perm = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (a_hitv[w]) begin
        sel_pfn  = sel_pfn | a_pfn[w];
        sel_perm = sel_perm | a_perm[w];
      end
    end
  end

  assign prot     = a_hit && ((lk_write && !sel_perm.wr) || (lk_user && !sel_perm.usr));
  assign clean_wr = a_hit && lk_write && !sel_perm.dirty && !prot;

  assign lk_fault   = lk_valid && prot;
  assign lk_hit     = lk_valid && a_hit && !prot && !clean_wr;
  assign lk_miss    = lk_valid && !lk_hit && !lk_fault;
  assign lk_ready   = lk_hit || lk_fault;
  assign walk_valid = lk_miss;
  assign walk_vpn   = lk_vpn;
  assign lk_paddr   = lk_hit ? {sel_pfn, lk_vaddr[OFS_W-1:0]} : '0;

  always_comb begin
    lk_ecode = '0;
    if (lk_fault) begin
      lk_ecode[EC_PRES] = 1'b1;
      lk_ecode[EC_WR]   = lk_write;
      lk_ecode[EC_USR]  = lk_user;
    end
  end
endmodule

// File: rtl/xc_chk.sv
module xc_chk
  import xc_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_ready,
  input logic [VA_W-1:0]    lk_vaddr,
  input logic               lk_write,
  input logic               lk_user,
  input logic               lk_hit,
  input logic               lk_fault,
  input logic [ECODE_W-1:0] lk_ecode,
  input logic [VA_W-1:0]    lk_paddr,
  input logic               walk_valid,
  input logic [VPN_W-1:0]   walk_vpn,
  input logic               base_wr
);
  p_empty_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!lk_hit && !lk_fault));

  p_offset_passes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> (lk_paddr[OFS_W-1:0] == lk_vaddr[OFS_W-1:0]));

  p_stall_walks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_ready) |-> walk_valid);

  p_walk_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_valid |-> (!lk_ready && walk_vpn == lk_vaddr[VA_W-1:OFS_W]));

  p_fault_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> (lk_ecode[EC_PRES] && (lk_write || lk_user) && !walk_valid));

  p_flush_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    base_wr |=> (!lk_hit && !lk_fault));
endmodule

bind xlat_cache xc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .lk_vaddr(lk_vaddr), .lk_write(lk_write), .lk_user(lk_user),
  .lk_hit(lk_hit), .lk_fault(lk_fault), .lk_ecode(lk_ecode),
  .lk_paddr(lk_paddr), .walk_valid(walk_valid), .walk_vpn(walk_vpn),
  .base_wr(base_wr)
);

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_write = 1'b0, lk_user = 1'b0;
  logic [31:0] lk_vaddr = '0;
  logic        lk_ready, lk_hit, lk_miss, lk_fault, walk_valid;
  logic [2:0]  lk_ecode;
  logic [31:0] lk_paddr;
  logic [19:0] walk_vpn;
  logic        fill_valid = 1'b0, fill_writable = 1'b0, fill_user = 1'b0, fill_dirty = 1'b0;
  logic [19:0] fill_vpn = '0, fill_pfn = '0;
  logic        base_wr = 1'b0;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  xlat_cache uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready),
    .lk_vaddr(lk_vaddr), .lk_write(lk_write), .lk_user(lk_user),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_fault(lk_fault),
    .lk_ecode(lk_ecode), .lk_paddr(lk_paddr), .walk_valid(walk_valid),
    .walk_vpn(walk_vpn), .fill_valid(fill_valid), .fill_vpn(fill_vpn),
    .fill_pfn(fill_pfn), .fill_writable(fill_writable), .fill_user(fill_user),
    .fill_dirty(fill_dirty), .base_wr(base_wr)
  );

  // scoreboard queues
  logic [31:0] q_va[$];
  logic        q_hit[$];
  logic        q_fault[$];
  logic [2:0]  q_ec[$];
  logic [31:0] q_pa[$];
  string       q_req[$];

  task automatic look(input logic [31:0] va, input logic w, input logic u,
                      input logic eh, input logic ef, input logic [2:0] ec,
                      input logic [19:0] pfn, input string req);
    @(posedge clk); #1;
    lk_vaddr = va; lk_write = w; lk_user = u; lk_valid = 1'b1;
    q_va.push_back(va); q_hit.push_back(eh); q_fault.push_back(ef);
    q_ec.push_back(ec); q_pa.push_back({pfn, va[11:0]}); q_req.push_back(req);
    @(negedge clk); #1;
    lk_valid = 1'b0;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn,
                      input logic w, input logic u, input logic d, input logic fl);
    @(posedge clk); #1;
    fill_vpn = vpn; fill_pfn = pfn; fill_writable = w; fill_user = u;
    fill_dirty = d; fill_valid = 1'b1; base_wr = fl;
    @(posedge clk); #1;
    fill_valid = 1'b0; base_wr = 1'b0;
  endtask

  task automatic flush();
    @(posedge clk); #1;
    base_wr = 1'b1;
    @(posedge clk); #1;
    base_wr = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (q_req.size() != 0) begin
      logic [31:0] va, pa;
      logic        eh, ef, ew, ok;
      logic [2:0]  ec;
      string       rq;
      va = q_va.pop_front(); eh = q_hit.pop_front(); ef = q_fault.pop_front();
      ec = q_ec.pop_front(); pa = q_pa.pop_front(); rq = q_req.pop_front();
      ew = !eh && !ef;
      ok = (lk_hit == eh) && (lk_fault == ef) && (lk_miss == ew) &&
           (walk_valid == ew) && (lk_ready == (eh || ef)) &&
           (!eh || lk_paddr == pa) && (!ef || lk_ecode == ec) &&
           (!ew || walk_vpn == va[31:12]);
      checks++;
      if (!ok) begin
        errors++;
        $display("FAIL %s va=%h actual hit=%b fault=%b miss=%b rdy=%b ec=%b pa=%h wvpn=%h expected hit=%b fault=%b miss=%b ec=%b pa=%h",
                 rq, va, lk_hit, lk_fault, lk_miss, lk_ready, lk_ecode, lk_paddr,
                 walk_vpn, eh, ef, ew, ec, pa);
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (lk_hit || lk_fault || lk_ready || walk_valid) begin
      errors++;
      $display("FAIL R1 idle outputs actual hit=%b fault=%b rdy=%b walk=%b expected 0 0 0 0",
               lk_hit, lk_fault, lk_ready, walk_valid);
    end
    look(32'h0001_0123, 0, 1, 0, 0, 3'b000, 20'h0, "R1 empty miss");
    look(32'h0001_0123, 0, 1, 0, 0, 3'b000, 20'h0, "R3 walk request");

    fill(20'h00010, 20'hABCDE, 1, 1, 1, 0);
    look(32'h0001_0123, 0, 1, 1, 0, 3'b000, 20'hABCDE, "R2 read hit");
    look(32'h0001_0FFC, 1, 1, 1, 0, 3'b000, 20'hABCDE, "R2 write hit");

    fill(20'h00105, 20'h11105, 1, 1, 1, 0);
    fill(20'h00205, 20'h11205, 1, 1, 1, 0);
    fill(20'h00305, 20'h11305, 1, 1, 1, 0);
    fill(20'h00405, 20'h11405, 1, 1, 1, 0);
    look(32'h0010_5040, 0, 0, 1, 0, 3'b000, 20'h11105, "R4 way fill 1");
    look(32'h0020_5040, 0, 0, 1, 0, 3'b000, 20'h11205, "R4 way fill 2");
    look(32'h0030_5040, 0, 0, 1, 0, 3'b000, 20'h11305, "R4 way fill 3");
    look(32'h0040_5040, 0, 0, 1, 0, 3'b000, 20'h11405, "R4 way fill 4");
    look(32'h0001_0000, 0, 0, 1, 0, 3'b000, 20'hABCDE, "R4 other set kept");
    look(32'h0010_6000, 0, 0, 0, 0, 3'b000, 20'h0, "R4 neighbour set miss");

    fill(20'h00505, 20'h11505, 1, 1, 1, 0);
    look(32'h0010_5040, 0, 0, 0, 0, 3'b000, 20'h0, "R5 first evicted");
    look(32'h0020_5040, 0, 0, 1, 0, 3'b000, 20'h11205, "R5 second kept");
    look(32'h0050_5040, 0, 0, 1, 0, 3'b000, 20'h11505, "R5 new resident");
    fill(20'h00605, 20'h11605, 1, 1, 1, 0);
    look(32'h0020_5040, 0, 0, 0, 0, 3'b000, 20'h0, "R5 second evicted");
    look(32'h0030_5040, 0, 0, 1, 0, 3'b000, 20'h11305, "R5 third kept");
    look(32'h0060_5040, 0, 0, 1, 0, 3'b000, 20'h11605, "R5 newest resident");

    fill(20'h00305, 20'h22305, 1, 1, 1, 0);
    look(32'h0030_5ABC, 0, 0, 1, 0, 3'b000, 20'h22305, "R6 updated in place");
    look(32'h0040_5040, 0, 0, 1, 0, 3'b000, 20'h11405, "R6 no eviction a");
    look(32'h0050_5040, 0, 0, 1, 0, 3'b000, 20'h11505, "R6 no eviction b");
    look(32'h0060_5040, 0, 0, 1, 0, 3'b000, 20'h11605, "R6 no eviction c");

    fill(20'h00777, 20'h07777, 0, 0, 0, 0);
    look(32'h0077_7010, 0, 0, 1, 0, 3'b000, 20'h07777, "R7 supervisor read");
    look(32'h0077_7010, 1, 0, 0, 1, 3'b011, 20'h0, "R7 write read-only");
    look(32'h0077_7010, 0, 1, 0, 1, 3'b101, 20'h0, "R8 user read supervisor");
    look(32'h0077_7010, 1, 1, 0, 1, 3'b111, 20'h0, "R8 user write both");

    fill(20'h00888, 20'h08888, 1, 1, 0, 0);
    look(32'h0088_8100, 0, 1, 1, 0, 3'b000, 20'h08888, "R9 clean read hit");
    look(32'h0088_8100, 1, 1, 0, 0, 3'b000, 20'h0, "R9 clean write misses");
    fill(20'h00888, 20'h08888, 1, 1, 1, 0);
    look(32'h0088_8100, 1, 1, 1, 0, 3'b000, 20'h08888, "R9 dirty write hit");

    flush();
    look(32'h0001_0123, 0, 1, 0, 0, 3'b000, 20'h0, "R10 flushed a");
    look(32'h0088_8100, 0, 1, 0, 0, 3'b000, 20'h0, "R10 flushed b");
    look(32'h0030_5ABC, 0, 0, 0, 0, 3'b000, 20'h0, "R10 flushed c");

    fill(20'h00010, 20'hABCDE, 1, 1, 1, 0);
    look(32'h0001_0123, 0, 1, 1, 0, 3'b000, 20'hABCDE, "R11 setup hit");
    fill(20'h00999, 20'h09999, 1, 1, 1, 1);
    look(32'h0099_9000, 0, 1, 0, 0, 3'b000, 20'h0, "R11 fill dropped");
    look(32'h0001_0123, 0, 1, 0, 0, 3'b000, 20'h0, "R11 flush applied");

    @(posedge clk);
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule